// File: doc/BRIEF.md
# Two-Wire Bus Connection Controller

This block decides when two separate two-wire buses, side A and side B, each with a data line and a clock line, may be joined. It sees only logic-level samples of the four lines, an enable input and a supply-good input, all taken on one system clock. After supply is good and enable is high, it waits until the transactions in flight on both sides have finished before it joins the buses. A safe moment is either both buses idle, or a stop condition on one bus while the other bus is idle. On joining, it releases its open-drain ready pull-down.

While the buses are joined, the block imitates a wired-AND join. A low driven by an outside device on one side is copied to the matching line on the other side through a pull-down enable. The block records which side started each low, so its own copied low is never mistaken for an outside driver. After the originating side lets go, a short guard window lets the released line settle through the synchronizers. If the other side is still held low at that point, the pull-down moves across to the first side. Analog offset, level translation and edge-rate sensing are left to the pads.

There are four connection states. LOCKOUT is entered from reset and whenever supply-good drops. DISABLED means enable is low. WAIT means enabled but looking for a safe boundary. JOINED means connected. The transitions are:
- LOCKOUT to WAIT, or to DISABLED, once supply is good, chosen by the level of enable.
- DISABLED to WAIT on enable high.
- DISABLED straight to JOINED on an enable rising edge while the fault latch is set.
- WAIT to JOINED on a safe boundary.
- WAIT or JOINED to DISABLED on enable low.
- Any state to LOCKOUT on supply loss.

The fault latch is set when WAIT lasts STUCK_CYCLES cycles. Each line pair has its own mirror machine with four states:
- FREE: nothing is driven.
- A_HOLDS: A started the low, so B is driven.
- B_HOLDS: B started the low, so A is driven.
- GUARD: the holding side has just let go.

The mirror moves FREE to A_HOLDS or B_HOLDS when a low appears, A_HOLDS or B_HOLDS to GUARD when the originator lets go, and GUARD to FREE after GUARD_CYCLES cycles. It returns to FREE whenever the buses are not joined.

Top module: `bus_join_ctrl`

## Requirements
- R1: While synchronized supply-good is low the block is in LOCKOUT: ready_pd is 1, all four line pull-downs are 0, and bus activity causes no connection.
- R2: A side counts as idle once both of its synchronized lines have read high for IDLE_CYCLES consecutive cycles; any low sample restarts the count. With both sides idle in WAIT the block joins.
- R3: A stop condition (data rising while that side's clock is high) on one side while the other side is idle joins the buses without waiting for the stopping side's idle time.
- R4: Enable low breaks the connection within SYNC_STAGES+1 cycles: ready_pd returns to 1 and every pull-down to 0, even while a line is held low.
- R5: Raising enable does not connect at once; with a side busy or stuck the block stays unjoined (ready_pd 1).
- R6: ready_pd is 0 exactly while the buses are joined, which needs enable high; out of reset it is 1.
- R7: While joined, an outside low on a side-A line drives the matching side-B pull-down (and B to A), held until the originating side releases. If the other side is still low after the guard window, the pull-down moves to the first side.
- R8: After WAIT has lasted STUCK_CYCLES cycles, a later enable rising edge joins the buses immediately, even with a line stuck low.
- R9: No pull-down is active while the buses are not joined.
- R10: When both sides of a pair go low in the same sample from FREE, side A is taken as the originator, so only the side-B pull-down is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-good; low holds LOCKOUT |
| enable | input | 1 | Connection enable |
| a_sda_i | input | 1 | Sampled level of side-A data line |
| a_scl_i | input | 1 | Sampled level of side-A clock line |
| b_sda_i | input | 1 | Sampled level of side-B data line |
| b_scl_i | input | 1 | Sampled level of side-B clock line |
| a_sda_pd | output | 1 | 1 pulls side-A data low |
| a_scl_pd | output | 1 | 1 pulls side-A clock low |
| b_sda_pd | output | 1 | 1 pulls side-B data low |
| b_scl_pd | output | 1 | 1 pulls side-B clock low |
| ready_pd | output | 1 | 1 activates the ready open-drain pull-down |

## Verification
Two cases are hard to reach from the ports. The first is the hand-over of a low: the originating side releases while the far side is still held externally, so the mirror must pass through its guard window without latching on its own copied low. The bench models the lines as a wired-AND of outside drivers and the block's own pull-downs, and overlaps outside lows on both sides. The second is the fault path: the bench holds a data line stuck through a full WAIT period, drops enable and raises it again, and expects an immediate join.

// File: rtl/bjc_pkg.sv
package bjc_pkg;

    typedef enum logic [1:0] {
        ST_LOCKOUT  = 2'd0,
        ST_DISABLED = 2'd1,
        ST_WAIT     = 2'd2,
        ST_JOINED   = 2'd3
    } conn_state_e;

    typedef enum logic [1:0] {
        M_FREE    = 2'd0,
        M_A_HOLDS = 2'd1,
        M_B_HOLDS = 2'd2,
        M_GUARD   = 2'd3
    } mir_state_e;

    localparam int NUM_SIDES = 2;
    localparam int NUM_PAIRS = 2;

endpackage

// File: rtl/bjc_sync.sv
module bjc_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/bjc_side_mon.sv
module bjc_side_mon #(
    parameter int IDLE_CYCLES = 11875
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sda,
    input  logic scl,
    output logic idle,
    output logic stop
);

    localparam int               CW       = $clog2(IDLE_CYCLES + 1);
    localparam logic [CW-1:0]    IDLE_LIM = CW'(IDLE_CYCLES);

    logic [CW-1:0] cnt_q;
    logic          sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            sda_prev_q <= 1'b1;
        end else begin
            sda_prev_q <= sda;
            if (clear || !(sda && scl))
                cnt_q <= '0;
            else if (cnt_q != IDLE_LIM)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        idle = (cnt_q == IDLE_LIM);
        stop = sda && !sda_prev_q && scl;
    end

    AST_IDLE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> $past(sda && scl)); // R2
    AST_IDLE_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && sda && scl && !clear) |=> idle); // R2

endmodule

// File: rtl/bjc_mirror.sv
module bjc_mirror import bjc_pkg::*; #(
    parameter int GUARD_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conn,
    input  logic a_lo,
    input  logic b_lo,
    output logic a_pd,
    output logic b_pd
);

    localparam int            GW    = $clog2(GUARD_CYCLES + 1);
    localparam logic [GW-1:0] G_LIM = GW'(GUARD_CYCLES);

    mir_state_e    m_q, m_d;
    logic [GW-1:0] g_q, g_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= M_FREE;
            g_q <= '0;
        end else begin
            m_q <= m_d;
            g_q <= g_d;
        end
    end

    always_comb begin
        m_d = m_q;
        g_d = g_q;
        if (!conn) begin
            m_d = M_FREE;
            g_d = '0;
        end else begin
            unique case (m_q)
                M_FREE: begin
                    if (a_lo)      m_d = M_A_HOLDS;
                    else if (b_lo) m_d = M_B_HOLDS;
                end
                M_A_HOLDS: begin
                    if (!a_lo) begin
                        m_d = M_GUARD;
                        g_d = G_LIM;
                    end
                end
                M_B_HOLDS: begin
                    if (!b_lo) begin
                        m_d = M_GUARD;
                        g_d = G_LIM;
                    end
                end
                M_GUARD: begin
                    if (g_q <= 1) begin
                        m_d = M_FREE;
                        g_d = '0;
                    end else begin
                        g_d = g_q - 1'b1;
                    end
                end
                default: m_d = M_FREE;
            endcase
        end
    end

    always_comb begin
        a_pd = conn && (m_q == M_B_HOLDS);
        b_pd = conn && (m_q == M_A_HOLDS);
    end

    AST_SINGLE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_pd && b_pd)); // R7
    AST_HOLD_WHILE_ORIGIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (b_pd && a_lo && conn) |=> (b_pd || !conn)); // R7
    AST_QUIET_UNJOINED: assert property (@(posedge clk) disable iff (!rst_n)
        !conn |-> (!a_pd && !b_pd)); // R9

endmodule

// File: rtl/bus_join_ctrl.sv
module bus_join_ctrl import bjc_pkg::*; #(
    parameter int IDLE_CYCLES  = 11875,
    parameter int STUCK_CYCLES = 1000000,
    parameter int SYNC_STAGES  = 2,
    parameter int GUARD_CYCLES = SYNC_STAGES + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic enable,
    input  logic a_sda_i,
    input  logic a_scl_i,
    input  logic b_sda_i,
    input  logic b_scl_i,
    output logic a_sda_pd,
    output logic a_scl_pd,
    output logic b_sda_pd,
    output logic b_scl_pd,
    output logic ready_pd
);

    localparam int            WW    = $clog2(STUCK_CYCLES + 1);
    localparam logic [WW-1:0] W_LIM = WW'(STUCK_CYCLES);

    // synchronized inputs: {supply, enable, b_scl, b_sda, a_scl, a_sda}
    logic [5:0] raw, syn;
    assign raw = {supply_ok, enable, b_scl_i, b_sda_i, a_scl_i, a_sda_i};

    bjc_sync #(.WIDTH(6), .STAGES(SYNC_STAGES), .RST_VAL(6'b001111)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    logic sup_s, en_s;
    logic [NUM_PAIRS-1:0] a_line_s, b_line_s;
    assign a_line_s = syn[1:0];
    assign b_line_s = syn[3:2];
    assign en_s     = syn[4];
    assign sup_s    = syn[5];

    conn_state_e   state_q, state_d;
    logic          en_prev_q;
    logic [WW-1:0] wait_cnt_q;
    logic          fault_q;
    logic          joined;

    // per-side monitors
    logic [NUM_SIDES-1:0] side_idle, side_stop;
    logic [NUM_SIDES-1:0] side_sda, side_scl;
    assign side_sda = {b_line_s[0], a_line_s[0]};
    assign side_scl = {b_line_s[1], a_line_s[1]};

    generate
        for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
            bjc_side_mon #(.IDLE_CYCLES(IDLE_CYCLES)) u_mon (
                .clk   (clk),
                .rst_n (rst_n),
                .clear (state_q == ST_LOCKOUT),
                .sda   (side_sda[s]),
                .scl   (side_scl[s]),
                .idle  (side_idle[s]),
                .stop  (side_stop[s])
            );
        end
    endgenerate

    logic join_ok, en_rise;
    always_comb begin
        join_ok = (side_idle[0] && side_idle[1]) ||
                  (side_stop[0] && side_idle[1]) ||
                  (side_stop[1] && side_idle[0]);
        en_rise = en_s && !en_prev_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_LOCKOUT;
            en_prev_q  <= 1'b0;
            wait_cnt_q <= '0;
            fault_q    <= 1'b0;
        end else begin
            state_q   <= state_d;
            en_prev_q <= en_s;
            if (state_q != ST_WAIT)
                wait_cnt_q <= '0;
            else if (wait_cnt_q != W_LIM)
                wait_cnt_q <= wait_cnt_q + 1'b1;
            if (state_q == ST_LOCKOUT || state_q == ST_JOINED)
                fault_q <= 1'b0;
            else if (state_q == ST_WAIT && wait_cnt_q == W_LIM)
                fault_q <= 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!sup_s) begin
            state_d = ST_LOCKOUT;
        end else begin
            unique case (state_q)
                ST_LOCKOUT:  state_d = en_s ? ST_WAIT : ST_DISABLED;
                ST_DISABLED: begin
                    if (en_s) state_d = (en_rise && fault_q) ? ST_JOINED : ST_WAIT;
                end
                ST_WAIT: begin
                    if (!en_s)        state_d = ST_DISABLED;
                    else if (join_ok) state_d = ST_JOINED;
                end
                ST_JOINED: begin
                    if (!en_s) state_d = ST_DISABLED;
                end
                default: state_d = ST_LOCKOUT;
            endcase
        end
    end

    // outputs
    always_comb begin
        joined   = (state_q == ST_JOINED);
        ready_pd = !joined;
    end

    logic [NUM_PAIRS-1:0] a_pd_v, b_pd_v;
    generate
        for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
            bjc_mirror #(.GUARD_CYCLES(GUARD_CYCLES)) u_mir (
                .clk   (clk),
                .rst_n (rst_n),
                .conn  (joined),
                .a_lo  (!a_line_s[p]),
                .b_lo  (!b_line_s[p]),
                .a_pd  (a_pd_v[p]),
                .b_pd  (b_pd_v[p])
            );
        end
    endgenerate

    assign a_sda_pd = a_pd_v[0];
    assign a_scl_pd = a_pd_v[1];
    assign b_sda_pd = b_pd_v[0];
    assign b_scl_pd = b_pd_v[1];

    AST_LOCKOUT_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_s |=> (ready_pd && !a_sda_pd && !a_scl_pd && !b_sda_pd && !b_scl_pd)); // R1
    AST_ENABLE_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> ready_pd); // R4
    AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_pd |-> $past(en_s)); // R6
    AST_JOIN_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_pd) |-> $past(join_ok || (en_rise && fault_q))); // R3

endmodule

// File: tb/sim_bus_join_ctrl.sv
module sim_bus_join_ctrl;

    localparam int IDLE  = 40;
    localparam int STUCK = 100;
    localparam int GUARD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic enable = 1'b0;
    logic ea_sda = 1'b1, ea_scl = 1'b1, eb_sda = 1'b1, eb_scl = 1'b1;
    logic a_sda_pd, a_scl_pd, b_sda_pd, b_scl_pd, ready_pd;
    logic a_sda, a_scl, b_sda, b_scl;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    assign a_sda = ea_sda & ~a_sda_pd;
    assign a_scl = ea_scl & ~a_scl_pd;
    assign b_sda = eb_sda & ~b_sda_pd;
    assign b_scl = eb_scl & ~b_scl_pd;

    bus_join_ctrl #(.IDLE_CYCLES(IDLE), .STUCK_CYCLES(STUCK),
                    .SYNC_STAGES(2), .GUARD_CYCLES(GUARD)) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .enable(enable),
        .a_sda_i(a_sda), .a_scl_i(a_scl), .b_sda_i(b_sda), .b_scl_i(b_scl),
        .a_sda_pd(a_sda_pd), .a_scl_pd(a_scl_pd),
        .b_sda_pd(b_sda_pd), .b_scl_pd(b_scl_pd), .ready_pd(ready_pd)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // index: 0 a_sda, 1 a_scl, 2 b_sda, 3 b_scl, 4 enable, 5 supply
    bit m1 [6];
    bit m2 [6];
    int cnt [2];
    bit sprev [2];
    int mst;          // 0 lockout, 1 disabled, 2 wait, 3 joined
    bit enprev;
    int wcnt;
    bit flt;
    int mir [2];      // 0 free, 1 A holds, 2 B holds, 3 guard
    int mg [2];

    function automatic bit [4:0] model_out();
        bit [4:0] o;
        bit c;
        c = (mst == 3);
        o[4] = !c;
        o[0] = c && mir[0] == 2;  // a_sda_pd
        o[1] = c && mir[1] == 2;  // a_scl_pd
        o[2] = c && mir[0] == 1;  // b_sda_pd
        o[3] = c && mir[1] == 1;  // b_scl_pd
        return o;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 6; i++) begin
            m1[i] = (i < 4);
            m2[i] = (i < 4);
        end
        cnt[0] = 0; cnt[1] = 0; sprev[0] = 1; sprev[1] = 1;
        mst = 0; enprev = 0; wcnt = 0; flt = 0;
        mir[0] = 0; mir[1] = 0; mg[0] = 0; mg[1] = 0;
    endtask

    task automatic model_step(input bit [5:0] lines);
        bit s [6];
        bit idle [2];
        bit stp [2];
        bit jok, erise, conn;
        int nst;
        for (int i = 0; i < 6; i++) s[i] = m2[i];
        for (int k = 0; k < 2; k++) begin
            idle[k] = (cnt[k] == IDLE);
            stp[k]  = s[2*k] && !sprev[k] && s[2*k+1];
        end
        jok   = (idle[0] && idle[1]) || (stp[0] && idle[1]) || (stp[1] && idle[0]);
        erise = s[4] && !enprev;
        conn  = (mst == 3);
        nst = mst;
        if (!s[5]) nst = 0;
        else if (mst == 0) nst = s[4] ? 2 : 1;
        else if (mst == 1) begin
            if (s[4]) nst = (erise && flt) ? 3 : 2;
        end else if (mst == 2) begin
            if (!s[4]) nst = 1; else if (jok) nst = 3;
        end else if (!s[4]) nst = 1;
        for (int k = 0; k < 2; k++) begin
            if (mst == 0 || !(s[2*k] && s[2*k+1])) cnt[k] = 0;
            else if (cnt[k] < IDLE) cnt[k]++;
            sprev[k] = s[2*k];
        end
        if (mst == 0 || mst == 3) flt = 0;
        else if (mst == 2 && wcnt == STUCK) flt = 1;
        if (mst != 2) wcnt = 0; else if (wcnt < STUCK) wcnt++;
        for (int p = 0; p < 2; p++) begin
            bit alo, blo;
            alo = !s[p];
            blo = !s[p+2];
            if (!conn) begin mir[p] = 0; mg[p] = 0; end
            else if (mir[p] == 0) begin
                if (alo) mir[p] = 1; else if (blo) mir[p] = 2;
            end else if (mir[p] == 1) begin
                if (!alo) begin mir[p] = 3; mg[p] = GUARD; end
            end else if (mir[p] == 2) begin
                if (!blo) begin mir[p] = 3; mg[p] = GUARD; end
            end else begin
                if (mg[p] <= 1) begin mir[p] = 0; mg[p] = 0; end
                else mg[p]--;
            end
        end
        mst = nst;
        enprev = s[4];
        for (int i = 0; i < 6; i++) begin
            m2[i] = m1[i];
            m1[i] = lines[i];
        end
    endtask

    initial begin
        model_reset();
        forever begin
            @(negedge clk);
            #3;
            begin
                bit [4:0] e;
                bit [4:0] a;
                e = model_out();
                a = {ready_pd, b_scl_pd, b_sda_pd, a_scl_pd, a_sda_pd};
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL MODEL R6/R7 outputs actual=%b expected=%b at %0t", a, e, $time);
                end
            end
            if (!rst_n) model_reset();
            else model_step({supply_ok, enable, b_scl, b_sda, a_scl, a_sda});
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        chk("R6 reset ready_pd", ready_pd, 1'b1);
        chk("R9 reset b_sda_pd", b_sda_pd, 1'b0);
        rst_n = 1'b1;

        // R1: lockout ignores bus activity
        enable = 1'b1;
        cyc(60);
        ea_sda = 1'b0; cyc(5); ea_sda = 1'b1;
        cyc(60);
        chk("R1 lockout ready_pd", ready_pd, 1'b1);
        chk("R1 lockout b_sda_pd", b_sda_pd, 1'b0);

        // R2: join after idle time on both sides
        supply_ok = 1'b1;
        cyc(20);
        chk("R2 not yet idle", ready_pd, 1'b1);
        cyc(40);
        chk("R2 joined after idle", ready_pd, 1'b0);
        chk("R6 ready when joined", ready_pd, 1'b0);

        // R7: mirror A->B, hand over to B, release
        ea_sda = 1'b0; cyc(5);
        chk("R7 b_sda_pd follows A low", b_sda_pd, 1'b1);
        chk("R7 a_sda_pd quiet", a_sda_pd, 1'b0);
        eb_sda = 1'b0; cyc(3);
        ea_sda = 1'b1; cyc(12);
        chk("R7 handover a_sda_pd", a_sda_pd, 1'b1);
        chk("R7 handover b_sda_pd", b_sda_pd, 1'b0);
        eb_sda = 1'b1; cyc(12);
        chk("R7 release a_sda_pd", a_sda_pd, 1'b0);
        chk("R7 line a_sda high", a_sda, 1'b1);

        // R10: simultaneous lows, A wins
        ea_scl = 1'b0; eb_scl = 1'b0; cyc(5);
        chk("R10 b_scl_pd", b_scl_pd, 1'b1);
        chk("R10 a_scl_pd", a_scl_pd, 1'b0);
        ea_scl = 1'b1; eb_scl = 1'b1; cyc(12);

        // R7: B->A on clock
        eb_scl = 1'b0; cyc(5);
        chk("R7 a_scl_pd follows B low", a_scl_pd, 1'b1);
        eb_scl = 1'b1; cyc(10);
        chk("R7 a_scl_pd released", a_scl_pd, 1'b0);

        // R4: enable low cuts even while held
        ea_sda = 1'b0; cyc(5);
        chk("R4 pre b_sda_pd", b_sda_pd, 1'b1);
        enable = 1'b0; cyc(4);
        chk("R4 ready_pd after enable low", ready_pd, 1'b1);
        chk("R9 b_sda_pd dropped", b_sda_pd, 1'b0);
        ea_sda = 1'b1;
        cyc(50);

        // R5/R3: enable with A busy, then stop on A
        ea_sda = 1'b0;
        enable = 1'b1;
        cyc(30);
        chk("R5 waits while A busy", ready_pd, 1'b1);
        ea_sda = 1'b1; cyc(5);
        chk("R3 join on stop", ready_pd, 1'b0);

        // R8: stuck line, fault, forced join on enable rise
        enable = 1'b0; cyc(5);
        ea_sda = 1'b0; cyc(5);
        enable = 1'b1; cyc(150);
        chk("R5 stuck stays unjoined", ready_pd, 1'b1);
        enable = 1'b0; cyc(6);
        enable = 1'b1; cyc(5);
        chk("R8 forced join", ready_pd, 1'b0);
        cyc(2);
        chk("R8 mirror after forced join", b_sda_pd, 1'b1);
        ea_sda = 1'b1; cyc(10);

        // R1: supply loss while joined
        supply_ok = 1'b0; cyc(4);
        chk("R1 supply loss ready_pd", ready_pd, 1'b1);
        ea_sda = 1'b0; cyc(10);
        chk("R1 no mirror in lockout", b_sda_pd, 1'b0);
        ea_sda = 1'b1; cyc(5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule